// File: doc/BRIEF.md
# Two-Dimensional Parity Block Corrector

This block guards short blocks of 7-bit words with a row-and-column parity code. It has a transmit path and a receive path, and each path has valid/ready handshakes on both sides. The transmit path takes six data words. It sends each word out with an even-parity bit attached. After the sixth row it sends one extra row that holds the column-wise parity of the six coded rows.

The receive path takes the seven coded rows of a block and stores them. While the rows arrive, it builds one failing-check vector per row and one per column. When exactly one row check and exactly one column check fail, the bit where they cross is the error, and that bit is inverted. Any other nonzero pattern is reported as uncorrectable, and the received data is passed through unchanged. The six data words then leave on handshaken beats, together with a status code and a first-word marker.

Top module: `tdp_corrector`

## Requirements
- R1: Each encoder beat for an input word carries the word in bits 7:1 and, in bit 0, a bit that is 1 exactly when the word has an odd number of ones. Every coded row therefore has even parity.
- R2: After the six word rows, the encoder sends a seventh row. Each of its bits is the XOR of the same bit position over the six coded rows, bit 0 included.
- R3: The encoder emits its rows in input order, seven beats for every six accepted words. While enc_out_valid is high and enc_out_ready is low, the row on enc_out_row does not change.
- R4: The decoder accepts exactly seven rows per block and no input while it is emitting. It presents six data words in row order (bits 7:1 of each stored row, after any correction), starting the cycle after the seventh row is accepted.
- R5: If no row check and no column check fails, dec_out_status is 2'b00 (clean) and the words are delivered as received.
- R6: If a single data bit is flipped, dec_out_status is 2'b01 (corrected) and the original words are delivered.
- R7: If a single parity bit is flipped, either bit 0 of a row or any bit of the seventh row, dec_out_status is 2'b01 and the original words are delivered.
- R8: Any other nonzero pattern of failing checks gives dec_out_status 2'b10 (uncorrectable), and bits 7:1 of the received rows are delivered unmodified. Two flipped bits always fall under this rule.
- R9: dec_out_first is high on the first of the six output beats and low on the others. The status code is valid on every output beat. Data, status and dec_out_first hold steady while dec_out_valid is high and dec_out_ready is low.
- R10: After a synchronous active-high reset, both input readies are high and both output valids are low. The decoder takes a new block as soon as the last word of the previous one has been handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder data word valid |
| enc_in_ready | output | 1 | Encoder can take a word |
| enc_in_data | input | 7 | Data word to encode |
| enc_out_valid | output | 1 | Coded row valid |
| enc_out_ready | input | 1 | Downstream takes the coded row |
| enc_out_row | output | 8 | Coded row: word in 7:1, parity in 0, or the column parity row |
| dec_in_valid | input | 1 | Received row valid |
| dec_in_ready | output | 1 | Decoder can take a row |
| dec_in_row | input | 8 | Received coded row |
| dec_out_valid | output | 1 | Decoded word valid |
| dec_out_ready | input | 1 | Downstream takes the word |
| dec_out_data | output | 7 | Decoded data word |
| dec_out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| dec_out_first | output | 1 | First word of the block |

## Verification
The assertions assume that a block offered to the decoder is exactly seven rows aligned to its start, with no framing slips. They also assume that upstream holds its data stable while ready is low. The stimulus always sends whole seven-row blocks, built from the encoder's own output, and changes inputs only after a handshake. Bit flips are limited to zero, one or two distinct positions per block, with directed single flips in both the parity column and the parity row. This covers every status outcome the decoder can reach.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    localparam int DATA_W    = 7;
    localparam int DATA_ROWS = 6;
    localparam int ROW_W     = DATA_W + 1;
    localparam int BLK_ROWS  = DATA_ROWS + 1;
    localparam int CNT_W     = $clog2(BLK_ROWS + 1);
    localparam int SYN_W     = (BLK_ROWS > ROW_W) ? BLK_ROWS : ROW_W;

    typedef enum logic [1:0] {
        BLK_CLEAN = 2'b00,
        BLK_FIXED = 2'b01,
        BLK_BAD   = 2'b10
    } blk_status_e;

    typedef enum logic {
        DEC_RECV = 1'b0,
        DEC_SEND = 1'b1
    } dec_state_e;

    // Coded row: data in the upper bits, even-parity bit in bit 0
    function automatic logic [ROW_W-1:0] make_row(input logic [DATA_W-1:0] d);
        return {d, ^d};
    endfunction

    function automatic logic single_bit(input logic [SYN_W-1:0] v);
        return (v != '0) && ((v & (v - SYN_W'(1))) == '0);
    endfunction
endpackage

// File: rtl/tdp_encoder.sv
module tdp_encoder
    import tdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ROW_W-1:0]  out_row
);
    localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(DATA_ROWS - 1);

    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic [ROW_W-1:0] acc;
    logic             slot;

    assign slot     = !out_valid || out_ready;
    assign in_ready = slot && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            pend      <= 1'b0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_row   <= '0;
        end else if (in_valid && in_ready) begin
            out_row   <= make_row(in_data);
            acc       <= acc ^ make_row(in_data);
            out_valid <= 1'b1;
            if (cnt == LAST_ROW) begin
                cnt  <= '0;
                pend <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else if (pend && slot) begin
            out_row   <= acc;
            out_valid <= 1'b1;
            pend      <= 1'b0;
            acc       <= '0;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1
    enc_even_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (^out_row) == 1'b0);

    // R3
    enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_row));
endmodule

// File: rtl/tdp_classify.sv
module tdp_classify
    import tdp_pkg::*;
(
    input  logic [BLK_ROWS-1:0] row_syn,
    input  logic [ROW_W-1:0]    col_syn,
    output logic                fixable,
    output blk_status_e         status
);
    always_comb begin
        fixable = single_bit(SYN_W'(row_syn)) && single_bit(SYN_W'(col_syn));
        if (row_syn == '0 && col_syn == '0)
            status = BLK_CLEAN;
        else if (fixable)
            status = BLK_FIXED;
        else
            status = BLK_BAD;
    end
endmodule

// File: rtl/tdp_decoder.sv
module tdp_decoder
    import tdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ROW_W-1:0]  in_row,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_status,
    output logic              out_first
);
    localparam logic [CNT_W-1:0] LAST_IN  = CNT_W'(BLK_ROWS - 1);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(DATA_ROWS - 1);

    dec_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [ROW_W-1:0]    store [BLK_ROWS];
    logic [BLK_ROWS-1:0] row_syn;
    logic [ROW_W-1:0]    col_syn;
    logic                fixable;
    blk_status_e         status;
    logic [ROW_W-1:0]    fixed_row;

    tdp_classify u_class (
        .row_syn (row_syn),
        .col_syn (col_syn),
        .fixable (fixable),
        .status  (status)
    );

    assign in_ready  = (state == DEC_RECV);
    assign out_valid = (state == DEC_SEND);
    assign out_first = out_valid && (cnt == '0);

    always_comb begin
        fixed_row = store[cnt];
        if (fixable && row_syn[cnt])
            fixed_row = store[cnt] ^ col_syn;
    end

    assign out_data   = fixed_row[ROW_W-1:1];
    assign out_status = status;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DEC_RECV;
            cnt     <= '0;
            row_syn <= '0;
            col_syn <= '0;
        end else if (state == DEC_RECV) begin
            if (in_valid) begin
                row_syn[cnt] <= ^in_row;
                col_syn      <= col_syn ^ in_row;
                if (cnt == LAST_IN) begin
                    cnt   <= '0;
                    state <= DEC_SEND;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end else if (out_ready) begin
            if (cnt == LAST_OUT) begin
                cnt     <= '0;
                row_syn <= '0;
                col_syn <= '0;
                state   <= DEC_RECV;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (state == DEC_RECV && in_valid)
            store[cnt] <= in_row;
    end

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_status) && $stable(out_first));

    // R4
    dec_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R8
    dec_status_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_status));
endmodule

// File: rtl/tdp_corrector.sv
module tdp_corrector
    import tdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [ROW_W-1:0]  enc_out_row,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [ROW_W-1:0]  dec_in_row,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [DATA_W-1:0] dec_out_data,
    output logic [1:0]        dec_out_status,
    output logic              dec_out_first
);
    tdp_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_row   (enc_out_row)
    );

    tdp_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (dec_in_valid),
        .in_ready   (dec_in_ready),
        .in_row     (dec_in_row),
        .out_valid  (dec_out_valid),
        .out_ready  (dec_out_ready),
        .out_data   (dec_out_data),
        .out_status (dec_out_status),
        .out_first  (dec_out_first)
    );
endmodule

// File: tb/tdp_corrector_tb.sv
module tdp_corrector_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_in_valid = 1'b0;
    logic       enc_in_ready;
    logic [6:0] enc_in_data = '0;
    logic       enc_out_valid;
    logic       enc_out_ready = 1'b0;
    logic [7:0] enc_out_row;
    logic       dec_in_valid = 1'b0;
    logic       dec_in_ready;
    logic [7:0] dec_in_row = '0;
    logic       dec_out_valid;
    logic       dec_out_ready = 1'b0;
    logic [6:0] dec_out_data;
    logic [1:0] dec_out_status;
    logic       dec_out_first;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tdp_corrector u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_block(input int nflips, input int force_pos);
        logic [6:0] words [6];
        logic [7:0] tx [7];
        logic [7:0] rx [7];
        logic [7:0] got [$];
        int idx, outs, p0, p1, exp_st;
        bit stall;
        logic [7:0] last;
        logic [6:0] last_d;
        tx[6] = '0;
        for (int k = 0; k < 6; k++) begin
            words[k] = 7'($urandom);
            tx[k] = {words[k], ^words[k]};
            tx[6] = tx[6] ^ tx[k];
        end
        // encoder phase
        idx = 0; stall = 0; last = '0;
        while (got.size() < 7) begin
            @(negedge clk);
            if (stall) chk(enc_out_valid && enc_out_row == last, "R3",
                           "row held under stall", int'(enc_out_row), int'(last));
            enc_out_ready = ($urandom % 4) != 0;
            enc_in_valid = (idx < 6) && (($urandom % 4) != 0);
            enc_in_data = (idx < 6) ? words[idx] : 7'h0;
            #1;
            if (enc_in_valid && enc_in_ready) idx++;
            stall = enc_out_valid && !enc_out_ready;
            last = enc_out_row;
            if (enc_out_valid && enc_out_ready) begin
                if (got.size() < 6)
                    chk(enc_out_row == tx[got.size()], "R1", "data row",
                        int'(enc_out_row), int'(tx[got.size()]));
                else
                    chk(enc_out_row == tx[6], "R2", "column parity row",
                        int'(enc_out_row), int'(tx[6]));
                got.push_back(enc_out_row);
            end
        end
        @(negedge clk);
        enc_in_valid = 0; enc_out_ready = 0;
        chk(idx == 6, "R3", "words accepted per block", idx, 6);
        // inject flips
        for (int k = 0; k < 7; k++) rx[k] = got[k];
        p0 = (force_pos >= 0) ? force_pos : int'($urandom % 56);
        p1 = p0;
        while (p1 == p0) p1 = int'($urandom % 56);
        if (nflips >= 1) rx[p0/8][p0%8] = ~rx[p0/8][p0%8];
        if (nflips >= 2) rx[p1/8][p1%8] = ~rx[p1/8][p1%8];
        exp_st = nflips;
        // decoder phase
        idx = 0; outs = 0; stall = 0; last_d = '0;
        while (outs < 6) begin
            @(negedge clk);
            if (stall) chk(dec_out_valid && dec_out_data == last_d, "R9",
                           "word held under stall", int'(dec_out_data), int'(last_d));
            if (dec_out_valid) chk(!dec_in_ready, "R4", "no input while sending",
                                   int'(dec_in_ready), 0);
            dec_out_ready = ($urandom % 4) != 0;
            dec_in_valid = (idx < 7) && (($urandom % 4) != 0);
            dec_in_row = (idx < 7) ? rx[idx] : 8'h0;
            #1;
            if (dec_in_valid && dec_in_ready) idx++;
            stall = dec_out_valid && !dec_out_ready;
            last_d = dec_out_data;
            if (dec_out_valid && dec_out_ready) begin
                logic [6:0] expd;
                expd = (nflips == 2) ? rx[outs][7:1] : words[outs];
                chk(dec_out_data == expd,
                    (nflips == 0) ? "R5" : (nflips == 2) ? "R8" :
                    (p0 % 8 == 0 || p0 >= 48) ? "R7" : "R6",
                    "decoded word", int'(dec_out_data), int'(expd));
                chk(dec_out_first == (outs == 0), "R9", "first marker",
                    int'(dec_out_first), int'(outs == 0));
                if (outs == 0)
                    chk(int'(dec_out_status) == exp_st,
                        (nflips == 0) ? "R5" : (nflips == 2) ? "R8" : "R6",
                        "status", int'(dec_out_status), exp_st);
                outs++;
            end
        end
        @(negedge clk);
        dec_in_valid = 0; dec_out_ready = 0;
        chk(idx == 7 && dec_in_ready, "R10", "ready for next block",
            int'(dec_in_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(enc_in_ready && !enc_out_valid, "R10", "encoder reset state",
            int'({enc_in_ready, enc_out_valid}), 2);
        chk(dec_in_ready && !dec_out_valid, "R10", "decoder reset state",
            int'({dec_in_ready, dec_out_valid}), 2);
        run_block(0, -1);
        run_block(1, 27);   // R6 data bit
        run_block(1, 0);    // R7 row parity bit
        run_block(1, 40);   // R7 row parity bit, last data row
        run_block(1, 48);   // R7 parity row, bit 0
        run_block(1, 55);   // R7 parity row, bit 7
        run_block(2, -1);   // R8
        for (int b = 0; b < 60; b++) run_block(int'($urandom % 3), -1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule